// File: doc/BRIEF.md
# Two-Wire Clock-Enable Configuration Slave

This block is a write-only slave on a two-wire serial bus (I2C) that decides which of ten copies of a reference clock are allowed to toggle. A system clock oversamples the bus clock and data lines and finds start and stop conditions. It then matches a fixed 7-bit device address. The first two bytes after the address are a mandatory header whose contents are thrown away. The next three bytes load the per-output enable bits, and any further bytes are acknowledged and dropped.

The enable bits gate the reference clock for each output. An enable change is applied on a falling edge of the reference clock, so an output never produces a shortened pulse. A global output-enable input turns off every pad driver at once. A disabled output is driven low and does not toggle. The block never returns data and has no register pointer: to change a later enable byte, the earlier ones must be resent.

Top module: `clkfan_cfg_slave`

## Requirements
- R1: After reset all ten enables are 1 and the slave does not pull the data line (`sda_oe_o` = 0).
- R2: The write address byte 0xD2 (address 0x69, R/W = 0) is acknowledged: `sda_oe_o` is 1 while the bus clock is high in the ninth clock, and it only changes while the bus clock is low.
- R3: An address byte other than 0xD2, including the read form 0xD3, gets no acknowledge. Every later byte up to the next start condition is also left unacknowledged and ignored. A repeated start begins a new address phase.
- R4: The two bytes after the address are acknowledged, and their contents change no enable.
- R5: In data byte 0, bits 3..0 set enables 3..0 (1 = on) and bits 7..4 are ignored. Enables change only while the slave is not driving an acknowledge.
- R6: In data byte 1, bits 7..4 set enables 7..4 and bits 3..0 are ignored.
- R7: In data byte 2, bit 7 sets enable 9 and bit 6 sets enable 8. The other bits are ignored.
- R8: Bytes after data byte 2 are acknowledged and change no enable.
- R9: A byte cut off by a stop condition before its eighth bit leaves its enables unchanged.
- R10: An enabled output equals the reference clock, not inverted. A disabled output stays low. Every output is low while the reference clock is low.
- R11: While `oe_i` is 0, every `clk_oe_o` bit is 0, whatever the enables hold. While `oe_i` is 1, every bit is 1.
- R12: An output never changes while the reference clock stays high. Enable updates take effect on a falling edge of the reference clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line (wired level) |
| sda_oe_o | output | 1 | 1 pulls the data line low (acknowledge) |
| ref_clk_i | input | 1 | Reference clock to fan out |
| oe_i | input | 1 | Global output-driver enable, 0 = all off |
| clk_o | output | 10 | Gated clock outputs |
| clk_oe_o | output | 10 | Per-output pad driver enable, 0 = high impedance |

## Verification
A wrong bit or byte counter first shows on `sda_oe_o`. The acknowledge appears in the wrong clock slot or goes missing, which is visible on the ninth clock of the very next byte. A mismatch in the byte index or the bit mapping only shows on `clk_o`, a few reference-clock cycles after the stop condition, as a wrong set of toggling outputs. The bench therefore checks each acknowledge slot as it happens and compares the outputs after each transfer. A monitor watches every high phase of the reference clock for a mid-phase output change.

// File: rtl/clkfan_pkg.sv
package clkfan_pkg;
  localparam int NUM_OUT    = 10;
  localparam int DATA_BYTES = 3;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK,
    ST_SKIP
  } rx_state_t;

  // merge one received data byte into the enable vector
  function automatic logic [NUM_OUT-1:0] apply_byte(
    input logic [NUM_OUT-1:0] cur,
    input logic [1:0]         idx,
    input logic [7:0]         data
  );
    logic [NUM_OUT-1:0] nxt;
    nxt = cur;
    case (idx)
      2'd0: nxt[3:0] = data[3:0];
      2'd1: nxt[7:4] = data[7:4];
      2'd2: begin
        nxt[9] = data[7];
        nxt[8] = data[6];
      end
      default: nxt = cur;
    endcase
    return nxt;
  endfunction
endpackage

// File: rtl/i2c_line_monitor.sv
module i2c_line_monitor #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [SYNC_STAGES-1:0] scl_sh, sda_sh;
  logic scl_p, sda_p;
  logic scl_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_p  <= 1'b1;
      sda_p  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[SYNC_STAGES-2:0], scl_i};
      sda_sh <= {sda_sh[SYNC_STAGES-2:0], sda_i};
      scl_p  <= scl_sh[SYNC_STAGES-1];
      sda_p  <= sda_sh[SYNC_STAGES-1];
    end
  end

  assign scl_s     = scl_sh[SYNC_STAGES-1];
  assign sda_s     = sda_sh[SYNC_STAGES-1];
  assign scl_rise  = scl_s & ~scl_p;
  assign scl_fall  = ~scl_s & scl_p;
  assign start_det = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/i2c_wr_engine.sv
module i2c_wr_engine
  import clkfan_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR   = 7'h69,
  parameter int         HDR_BYTES  = 2,
  parameter int         DATA_BYTES_P = DATA_BYTES
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       sda_s,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       start_det,
  input  logic       stop_det,
  output logic       sda_oe,
  output logic       wr_stb,
  output logic [1:0] wr_idx,
  output logic [7:0] wr_data
);
  localparam int CNT_W = $clog2(HDR_BYTES + DATA_BYTES_P + 2);
  localparam logic [CNT_W-1:0] FIRST_DATA = CNT_W'(1 + HDR_BYTES);
  localparam logic [CNT_W-1:0] END_DATA   = CNT_W'(1 + HDR_BYTES + DATA_BYTES_P);

  rx_state_t        state;
  logic [2:0]       bit_cnt;
  logic [7:0]       shreg;
  logic [CNT_W-1:0] byte_no;
  logic [7:0]       next_byte;

  assign next_byte = {shreg[6:0], sda_s};

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      bit_cnt <= '0;
      shreg   <= '0;
      byte_no <= '0;
      sda_oe  <= 1'b0;
      wr_stb  <= 1'b0;
      wr_idx  <= '0;
      wr_data <= '0;
    end else begin
      wr_stb <= 1'b0;
      if (start_det) begin
        state   <= ST_RX;
        bit_cnt <= '0;
        byte_no <= '0;
        sda_oe  <= 1'b0;
      end else if (stop_det) begin
        state  <= ST_IDLE;
        sda_oe <= 1'b0;
      end else begin
        case (state)
          ST_RX: begin
            if (scl_rise) begin
              shreg <= next_byte;
              if (bit_cnt == 3'd7) begin
                bit_cnt <= '0;
                if (byte_no == '0) begin
                  state <= (next_byte == {DEV_ADDR, 1'b0}) ? ST_ACK : ST_SKIP;
                end else begin
                  state <= ST_ACK;
                  if (byte_no >= FIRST_DATA && byte_no < END_DATA) begin
                    wr_stb  <= 1'b1;
                    wr_idx  <= 2'(byte_no - FIRST_DATA);
                    wr_data <= next_byte;
                  end
                end
              end else begin
                bit_cnt <= bit_cnt + 3'd1;
              end
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              if (!sda_oe) begin
                sda_oe <= 1'b1;
              end else begin
                sda_oe <= 1'b0;
                state  <= ST_RX;
                if (byte_no != END_DATA) byte_no <= byte_no + 1'b1;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/clk_enable_regs.sv
module clk_enable_regs
  import clkfan_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_stb,
  input  logic [1:0]         wr_idx,
  input  logic [7:0]         wr_data,
  output logic [NUM_OUT-1:0] en_q
);
  always_ff @(posedge clk) begin
    if (rst)         en_q <= '1;
    else if (wr_stb) en_q <= apply_byte(en_q, wr_idx, wr_data);
  end
endmodule

// File: rtl/clk_gate_bank.sv
module clk_gate_bank #(
  parameter int NUM_OUT     = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic               rst,
  input  logic               ref_clk_i,
  input  logic               oe_i,
  input  logic [NUM_OUT-1:0] en_q,
  output logic [NUM_OUT-1:0] clk_o,
  output logic [NUM_OUT-1:0] clk_oe_o
);
  logic [NUM_OUT-1:0] stg [SYNC_STAGES];

  // all stages clocked on the falling edge: the last stage only moves while ref is low
  always_ff @(negedge ref_clk_i) begin
    if (rst) begin
      for (int s = 0; s < SYNC_STAGES; s++) stg[s] <= '1;
    end else begin
      stg[0] <= en_q;
      for (int s = 1; s < SYNC_STAGES; s++) stg[s] <= stg[s-1];
    end
  end

  for (genvar i = 0; i < NUM_OUT; i++) begin : g_out
    assign clk_o[i]    = ref_clk_i & stg[SYNC_STAGES-1][i];
    assign clk_oe_o[i] = oe_i;
  end
endmodule

// File: rtl/clkfan_cfg_slave.sv
module clkfan_cfg_slave
  import clkfan_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h69,
  parameter int         HDR_BYTES   = 2,
  parameter int         SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_oe_o,
  input  logic               ref_clk_i,
  input  logic               oe_i,
  output logic [NUM_OUT-1:0] clk_o,
  output logic [NUM_OUT-1:0] clk_oe_o
);
  logic sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic wr_stb;
  logic [1:0] wr_idx;
  logic [7:0] wr_data;
  logic [NUM_OUT-1:0] en_q;

  i2c_line_monitor #(.SYNC_STAGES(SYNC_STAGES)) u_mon (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2c_wr_engine #(.DEV_ADDR(DEV_ADDR), .HDR_BYTES(HDR_BYTES), .DATA_BYTES_P(DATA_BYTES)) u_eng (
    .clk(clk), .rst(rst), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det), .sda_oe(sda_oe_o),
    .wr_stb(wr_stb), .wr_idx(wr_idx), .wr_data(wr_data)
  );

  clk_enable_regs u_regs (
    .clk(clk), .rst(rst), .wr_stb(wr_stb), .wr_idx(wr_idx), .wr_data(wr_data), .en_q(en_q)
  );

  clk_gate_bank #(.NUM_OUT(NUM_OUT), .SYNC_STAGES(SYNC_STAGES)) u_gate (
    .rst(rst), .ref_clk_i(ref_clk_i), .oe_i(oe_i), .en_q(en_q),
    .clk_o(clk_o), .clk_oe_o(clk_oe_o)
  );
endmodule

// File: rtl/clkfan_cfg_chk.sv
module clkfan_cfg_chk #(
  parameter int NUM_OUT = 10
) (
  input logic               clk,
  input logic               rst,
  input logic               scl_i,
  input logic               sda_oe_o,
  input logic               ref_clk_i,
  input logic [NUM_OUT-1:0] clk_o,
  input logic [NUM_OUT-1:0] en_q
);
  AST_RESET_ALL_ON: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (en_q == '1 && !sda_oe_o)); // R1

  AST_ACK_HOLD_HIGH: assert property (@(posedge clk) disable iff (rst)
    (scl_i && $past(scl_i)) |-> $stable(sda_oe_o)); // R2

  AST_ACK_RISE_LOW: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe_o) |-> !scl_i); // R2

  AST_REG_OUTSIDE_ACK: assert property (@(posedge clk) disable iff (rst)
    !$stable(en_q) |-> !sda_oe_o); // R5

  AST_LOW_WHEN_REF_LOW: assert property (@(posedge clk) disable iff (rst)
    !ref_clk_i |-> (clk_o == '0)); // R10

  AST_NO_RUNT: assert property (@(posedge clk) disable iff (rst)
    (ref_clk_i && $past(ref_clk_i)) |-> $stable(clk_o)); // R12
endmodule

bind clkfan_cfg_slave clkfan_cfg_chk #(.NUM_OUT(clkfan_pkg::NUM_OUT)) chk_i (
  .clk(clk), .rst(rst), .scl_i(scl_i), .sda_oe_o(sda_oe_o),
  .ref_clk_i(ref_clk_i), .clk_o(clk_o), .en_q(en_q)
);

// File: tb/clkfan_cfg_slave_tb_top.sv
module clkfan_cfg_slave_tb_top;
  localparam int Q = 8;

  logic clk = 1'b0;
  logic ref_clk = 1'b0;
  logic rst = 1'b1;
  logic m_scl = 1'b1;
  logic m_sda = 1'b1;
  logic oe = 1'b1;
  logic sda_oe;
  logic sda_bus;
  logic [9:0] clk_o, clk_oe;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;
  int glitches = 0;

  typedef struct {
    bit    exp;
    string tag;
  } ack_item_t;
  ack_item_t ack_q[$];
  event ack_ev;

  always #10 clk = ~clk;
  always #37 ref_clk = ~ref_clk;

  assign sda_bus = m_sda & ~sda_oe;

  clkfan_cfg_slave dut_i (
    .clk(clk), .rst(rst), .scl_i(m_scl), .sda_i(sda_bus), .sda_oe_o(sda_oe),
    .ref_clk_i(ref_clk), .oe_i(oe), .clk_o(clk_o), .clk_oe_o(clk_oe)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // monitor: pops the expected acknowledge for each ninth clock
  initial begin
    forever begin
      ack_item_t it;
      @(ack_ev);
      it = ack_q.pop_front();
      check(sda_oe == it.exp, it.tag, {31'd0, sda_oe}, {31'd0, it.exp});
    end
  end

  // R12: outputs must not move within a high phase of the reference clock
  logic prev_ref = 1'b0;
  logic [9:0] prev_out = '0;
  always @(negedge clk) begin
    if (!rst && ref_clk && prev_ref && clk_o != prev_out) glitches++;
    prev_ref <= ref_clk;
    prev_out <= clk_o;
  end

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; wq();
    m_scl = 1'b1; wq();
    m_sda = 1'b0; wq();
    m_scl = 1'b0; wq();
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; wq();
    m_scl = 1'b1; wq();
    m_sda = 1'b1; wq();
  endtask

  task automatic send_bit(input logic b);
    m_sda = b; wq();
    m_scl = 1'b1; wq(); wq();
    m_scl = 1'b0; wq();
  endtask

  task automatic send_byte(input logic [7:0] d, input bit exp_ack, input string tag);
    ack_item_t it;
    for (int i = 7; i >= 0; i--) send_bit(d[i]);
    it.exp = exp_ack;
    it.tag = tag;
    ack_q.push_back(it);
    m_sda = 1'b1; wq();
    m_scl = 1'b1; wq();
    ->ack_ev;
    wq();
    m_scl = 1'b0; wq();
  endtask

  task automatic send_partial(input logic [7:0] d, input int n);
    for (int i = 7; i > 7 - n; i--) send_bit(d[i]);
  endtask

  task automatic chk_outs(input logic [9:0] exp, input string tag);
    repeat (4) @(posedge ref_clk);
    @(posedge ref_clk); #5;
    check(clk_o == exp, tag, {22'd0, clk_o}, {22'd0, exp});
    @(negedge ref_clk); #5;
    check(clk_o == 10'd0, "R10", {22'd0, clk_o}, 32'd0);
  endtask

  initial begin
    repeat (10) @(negedge clk);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    // R1 reset state
    check(sda_oe == 1'b0, "R1", {31'd0, sda_oe}, 32'd0);
    chk_outs(10'h3FF, "R1");
    check(clk_oe == 10'h3FF, "R11", {22'd0, clk_oe}, 32'h3FF);

    // full write with mixed patterns
    bus_start();
    send_byte(8'hD2, 1'b1, "R2");
    send_byte(8'hFF, 1'b1, "R4");
    send_byte(8'hAA, 1'b1, "R4");
    send_byte(8'hF5, 1'b1, "R5");
    send_byte(8'h3F, 1'b1, "R6");
    send_byte(8'h40, 1'b1, "R7");
    bus_stop();
    chk_outs(10'b01_0011_0101, "R5 R6 R7 R10");

    // trailing bytes are acknowledged and dropped
    bus_start();
    send_byte(8'hD2, 1'b1, "R2");
    send_byte(8'h00, 1'b1, "R4");
    send_byte(8'h00, 1'b1, "R4");
    send_byte(8'h0F, 1'b1, "R5");
    send_byte(8'hF0, 1'b1, "R6");
    send_byte(8'hC0, 1'b1, "R7");
    send_byte(8'h00, 1'b1, "R8");
    send_byte(8'h00, 1'b1, "R8");
    bus_stop();
    chk_outs(10'h3FF, "R8");

    // foreign address: no ack, nothing written
    bus_start();
    send_byte(8'hA4, 1'b0, "R3");
    for (int k = 0; k < 4; k++) send_byte(8'h00, 1'b0, "R3");
    bus_stop();
    chk_outs(10'h3FF, "R3");

    // read form of own address is refused
    bus_start();
    send_byte(8'hD3, 1'b0, "R3");
    for (int k = 0; k < 4; k++) send_byte(8'h00, 1'b0, "R3");
    bus_stop();
    chk_outs(10'h3FF, "R3");

    // repeated start recovers from a foreign address
    bus_start();
    send_byte(8'hA4, 1'b0, "R3");
    bus_start();
    send_byte(8'hD2, 1'b1, "R3");
    send_byte(8'h00, 1'b1, "R4");
    send_byte(8'h00, 1'b1, "R4");
    send_byte(8'h0A, 1'b1, "R5");
    bus_stop();
    chk_outs(10'b11_1111_1010, "R3");

    // truncated second data byte keeps old value
    bus_start();
    send_byte(8'hD2, 1'b1, "R2");
    send_byte(8'h00, 1'b1, "R4");
    send_byte(8'h00, 1'b1, "R4");
    send_byte(8'h00, 1'b1, "R5");
    send_partial(8'h00, 4);
    bus_stop();
    chk_outs(10'b11_1111_0000, "R9");

    // global output enable
    oe = 1'b0;
    repeat (2) @(negedge clk);
    check(clk_oe == 10'd0, "R11", {22'd0, clk_oe}, 32'd0);
    oe = 1'b1;
    repeat (2) @(negedge clk);
    check(clk_oe == 10'h3FF, "R11", {22'd0, clk_oe}, 32'h3FF);

    check(glitches == 0, "R12", glitches, 32'd0);
    check(ack_q.size() == 0, "R2", ack_q.size(), 32'd0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule